// File: doc/BRIEF.md
# Next-Line Fetch Predictor with Instruction Queue

This block is the front end of an instruction fetch path. It holds the current fetch line address and presents it to the instruction cache. When the cache returns a group of four instructions for that line, the block queues the group for decode. In the same cycle it chooses the next line to fetch, so a predicted taken branch costs no more fetch cycles than straight-line code.

The next line comes from a small prediction table. The table is indexed by the low bits of the line address and has no tags. Each entry holds a next-line pointer and a two-bit saturating counter. When the counter predicts taken, fetch jumps to the stored pointer. Otherwise it moves on to the following line.

The branch unit reports each resolved branch through an update port, which steps the counter and, for a taken branch, rewrites the pointer. A mispredict flush empties the queue and sends fetch to the corrected line. Decode drains the queue one instruction per cycle through a valid/ready handshake. Fetch stalls whenever the queue cannot take a whole group, so no group is ever lost.

Top module: `fnl_fetch_front`

## Requirements
- R1: During reset and after it is released, `fetch_line_o` equals `RESET_LINE`, `fetch_req_o` is 1 and `dec_valid_o` is 0.
- R2: When a group is accepted (`grp_valid_i` and `fetch_req_o` high, no flush) and the entry for that line predicts not taken, `fetch_line_o` becomes the line plus one in the next cycle. Every entry's counter resets to 1.
- R3: Each entry's counter moves one step per update: up on taken and down on not taken. It saturates at 0 and at 3. Values 2 and 3 predict taken.
- R4: When an accepted group's entry predicts taken, `fetch_line_o` becomes the stored pointer in the very next cycle, with no idle fetch cycle in between.
- R5: A taken update writes `upd_target_i` into the entry's pointer. A not-taken update leaves the pointer unchanged.
- R6: The queue is first in, first out. Within a group, lane k is bits [k*INSTR_W +: INSTR_W], and lane 0 leaves first.
- R7: The queue never holds more than `DEPTH` instructions. `fetch_req_o` is 1 exactly when at least `LANES` slots are free. A group offered while `fetch_req_o` is 0 is not taken and the line does not advance.
- R8: A flush empties the queue, so `dec_valid_o` is 0 in the next cycle. `fetch_line_o` becomes `flush_line_i` in the next cycle. A flush overrides a group offered in the same cycle.
- R9: With no accepted group and no flush, `fetch_line_o` holds its value.
- R10: `dec_valid_o` is 1 whenever the queue is not empty. An instruction leaves only on `dec_valid_o && dec_ready_i`, and otherwise `dec_instr_o` holds.
- R11: The table is selected by the low `IDX_W` bits of the line address with no tag, so lines that share those bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_line_o | output | LINE_W | Line address presented to the cache |
| fetch_req_o | output | 1 | Queue has room for a whole group |
| grp_valid_i | input | 1 | Cache returned the group for `fetch_line_o` |
| grp_data_i | input | LANES*INSTR_W | Instruction group, lane 0 in the low bits |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_line_i | input | LINE_W | Line holding the resolved branch |
| upd_taken_i | input | 1 | Resolved direction |
| upd_target_i | input | LINE_W | Actual target line |
| flush_i | input | 1 | Mispredict flush |
| flush_line_i | input | LINE_W | Corrected fetch line |
| dec_valid_o | output | 1 | Queue head is valid |
| dec_instr_o | output | INSTR_W | Queue head instruction |
| dec_ready_i | input | 1 | Decode takes the head |

## Verification
The bench builds the block with an 8-bit line address, a 4-bit table index, 16-bit instructions, four lanes and a 12-entry queue. Each instruction encodes its own line and lane, so the bench can check ordering directly. With three groups filling the queue exactly, the full-queue stall and the drain back to room are easy to reach. Because the index is narrower than the line address, two lines that alias onto one entry can be chosen directly. Short runs of updates on one entry drive the counter into both saturation limits.

// File: rtl/fnl_pkg.sv
// Package: shared counter type and step function for the next-line predictor.
// Assumes two-bit counters where the upper half of the range predicts taken.
package fnl_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN  = 2'd0;
    localparam ctr_t CTR_MAX  = 2'd3;
    localparam ctr_t CTR_INIT = 2'd1;

    // One saturating step toward the resolved direction.
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        if (taken) begin
            return (c == CTR_MAX) ? c : c + 2'd1;
        end
        return (c == CTR_MIN) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/fnl_pred_table.sv
// Module: untagged next-line prediction table.
// Each entry holds a next-line pointer and a two-bit counter. The read side is
// combinational so the next fetch line is known in the same cycle as the
// lookup. Assumes at most one update per cycle.
module fnl_pred_table
    import fnl_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line_i,
    output logic [LINE_W-1:0] pred_next_o,
    input  logic              upd_valid_i,
    input  logic [LINE_W-1:0] upd_line_i,
    input  logic              upd_taken_i,
    input  logic [LINE_W-1:0] upd_target_i
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [LINE_W-1:0] ptr_q [ENTRIES];
    ctr_t              ctr_q [ENTRIES];
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  upd_idx;

    assign rd_idx  = rd_line_i[IDX_W-1:0];
    assign upd_idx = upd_line_i[IDX_W-1:0];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Step the counter and, on taken, capture the target line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[e] <= '0;
                ctr_q[e] <= CTR_INIT;
            end else if (upd_valid_i && (upd_idx == IDX_W'(e))) begin
                ctr_q[e] <= ctr_step(ctr_q[e], upd_taken_i);
                if (upd_taken_i) begin
                    ptr_q[e] <= upd_target_i;
                end
            end
        end
    end

    // Choose the stored pointer on a taken prediction, else the next line.
    always_comb begin
        if (ctr_q[rd_idx][1]) begin
            pred_next_o = ptr_q[rd_idx];
        end else begin
            pred_next_o = rd_line_i + LINE_W'(1);
        end
    end
endmodule

// File: rtl/fnl_inst_queue.sv
// Module: circular instruction queue, written a whole group at a time and
// read one instruction at a time. Assumes LANES <= DEPTH. The caller pushes
// only while can_push_o is high.
module fnl_inst_queue #(
    parameter int INSTR_W = 32,
    parameter int LANES   = 4,
    parameter int DEPTH   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic                     push_i,
    input  logic [LANES*INSTR_W-1:0] push_data_i,
    output logic                     can_push_o,
    output logic                     pop_valid_o,
    output logic [INSTR_W-1:0]       pop_data_o,
    input  logic                     pop_ready_i
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [INSTR_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr_q;
    logic [PTR_W-1:0]   rd_ptr_q;
    logic [CNT_W-1:0]   count_q;
    logic               do_push;
    logic               do_pop;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] base,
                                                  input int unsigned step);
        int unsigned sum;
        sum = int'(base) + step;
        if (sum >= DEPTH) begin
            sum = sum - DEPTH;
        end
        return PTR_W'(sum);
    endfunction

    assign can_push_o  = (int'(count_q) + LANES) <= DEPTH;
    assign pop_valid_o = (count_q != '0);
    assign pop_data_o  = mem_q[rd_ptr_q];
    assign do_push     = push_i && can_push_o && !flush_i;
    assign do_pop      = pop_valid_o && pop_ready_i && !flush_i;

    // Write every lane of an accepted group into consecutive slots.
    always_ff @(posedge clk) begin
        if (do_push) begin
            for (int k = 0; k < LANES; k++) begin
                mem_q[wrap_add(wr_ptr_q, unsigned'(k))] <= push_data_i[k*INSTR_W +: INSTR_W];
            end
        end
    end

    // Track pointers and occupancy; a flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= wrap_add(wr_ptr_q, unsigned'(LANES));
            end
            if (do_pop) begin
                rd_ptr_q <= wrap_add(rd_ptr_q, 1);
            end
            count_q <= count_q + (do_push ? CNT_W'(LANES) : CNT_W'(0))
                               - (do_pop ? CNT_W'(1) : CNT_W'(0));
        end
    end
endmodule

// File: rtl/fnl_fetch_front.sv
// Module: fetch front end (top). Holds the fetch line, accepts the cache's
// instruction group, and steers to the predicted next line in the same cycle.
// Assumes the cache answers combinationally for the presented line and that
// grp_valid_i low means the data is not yet available.
module fnl_fetch_front #(
    parameter int          LINE_W     = 8,
    parameter int          IDX_W      = 4,
    parameter int          INSTR_W    = 32,
    parameter int          LANES      = 4,
    parameter int          DEPTH      = 12,
    parameter logic [LINE_W-1:0] RESET_LINE = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [LINE_W-1:0]        fetch_line_o,
    output logic                     fetch_req_o,
    input  logic                     grp_valid_i,
    input  logic [LANES*INSTR_W-1:0] grp_data_i,
    input  logic                     upd_valid_i,
    input  logic [LINE_W-1:0]        upd_line_i,
    input  logic                     upd_taken_i,
    input  logic [LINE_W-1:0]        upd_target_i,
    input  logic                     flush_i,
    input  logic [LINE_W-1:0]        flush_line_i,
    output logic                     dec_valid_o,
    output logic [INSTR_W-1:0]       dec_instr_o,
    input  logic                     dec_ready_i
);
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] pred_next;
    logic              room;
    logic              accept;

    assign fetch_line_o = line_q;
    assign fetch_req_o  = room;
    assign accept       = grp_valid_i && room && !flush_i;

    fnl_pred_table #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_line_i   (line_q),
        .pred_next_o (pred_next),
        .upd_valid_i (upd_valid_i),
        .upd_line_i  (upd_line_i),
        .upd_taken_i (upd_taken_i),
        .upd_target_i(upd_target_i)
    );

    fnl_inst_queue #(.INSTR_W(INSTR_W), .LANES(LANES), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .push_i     (accept),
        .push_data_i(grp_data_i),
        .can_push_o (room),
        .pop_valid_o(dec_valid_o),
        .pop_data_o (dec_instr_o),
        .pop_ready_i(dec_ready_i)
    );

    // Advance the fetch line: flush first, then prediction on accept, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= RESET_LINE;
        end else if (flush_i) begin
            line_q <= flush_line_i;
        end else if (accept) begin
            line_q <= pred_next;
        end
    end
endmodule

// File: rtl/fnl_fetch_front_chk.sv
// Module: assertion checker for the fetch front end, attached by bind.
// Keeps a shadow occupancy count built only from port handshakes.
module fnl_fetch_front_chk #(
    parameter int LINE_W  = 8,
    parameter int INSTR_W = 32,
    parameter int LANES   = 4,
    parameter int DEPTH   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LINE_W-1:0]  fetch_line_o,
    input logic               fetch_req_o,
    input logic               grp_valid_i,
    input logic               flush_i,
    input logic [LINE_W-1:0]  flush_line_i,
    input logic               dec_valid_o,
    input logic [INSTR_W-1:0] dec_instr_o,
    input logic               dec_ready_i
);
    localparam int OCC_W = $clog2(DEPTH + LANES + 1);

    logic [OCC_W-1:0] occ_q;

    // Shadow occupancy from accepted groups and decode handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + ((grp_valid_i && fetch_req_o) ? OCC_W'(LANES) : OCC_W'(0))
                           - ((dec_valid_o && dec_ready_i) ? OCC_W'(1) : OCC_W'(0));
        end
    end

    AST_FLUSH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (fetch_line_o == $past(flush_line_i)) && !dec_valid_o); // R8

    AST_HOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !(grp_valid_i && fetch_req_o)) |=> $stable(fetch_line_o)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_q) <= DEPTH); // R7

    AST_REQ_MATCHES_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o == ((int'(occ_q) + LANES) <= DEPTH)); // R7

    AST_VALID_MATCHES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o == (occ_q != '0)); // R10

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && !dec_ready_i && !flush_i) |=> $stable(dec_instr_o)); // R10
endmodule

bind fnl_fetch_front fnl_fetch_front_chk #(
    .LINE_W (LINE_W),
    .INSTR_W(INSTR_W),
    .LANES  (LANES),
    .DEPTH  (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_line_o(fetch_line_o),
    .fetch_req_o (fetch_req_o),
    .grp_valid_i (grp_valid_i),
    .flush_i     (flush_i),
    .flush_line_i(flush_line_i),
    .dec_valid_o (dec_valid_o),
    .dec_instr_o (dec_instr_o),
    .dec_ready_i (dec_ready_i)
);

// File: tb/test_fnl_fetch_front.sv
// Directed bench for the fetch front end: one task per scenario.
module test_fnl_fetch_front;
    localparam int LINE_W  = 8;
    localparam int IDX_W   = 4;
    localparam int INSTR_W = 16;
    localparam int LANES   = 4;
    localparam int DEPTH   = 12;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [LINE_W-1:0]        fetch_line_o;
    logic                     fetch_req_o;
    logic                     grp_valid_i = 1'b0;
    logic [LANES*INSTR_W-1:0] grp_data_i;
    logic                     upd_valid_i = 1'b0;
    logic [LINE_W-1:0]        upd_line_i = '0;
    logic                     upd_taken_i = 1'b0;
    logic [LINE_W-1:0]        upd_target_i = '0;
    logic                     flush_i = 1'b0;
    logic [LINE_W-1:0]        flush_line_i = '0;
    logic                     dec_valid_o;
    logic [INSTR_W-1:0]       dec_instr_o;
    logic                     dec_ready_i = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [INSTR_W-1:0] sb [$];

    always #5 clk = ~clk;

    // Cache model: lane k of line L carries {L, k}.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            grp_data_i[k*INSTR_W +: INSTR_W] = {fetch_line_o, 8'(k)};
        end
    end

    fnl_fetch_front #(
        .LINE_W(LINE_W), .IDX_W(IDX_W), .INSTR_W(INSTR_W),
        .LANES(LANES), .DEPTH(DEPTH), .RESET_LINE(8'h00)
    ) i_fnl_fetch_front (
        .clk(clk), .rst_n(rst_n),
        .fetch_line_o(fetch_line_o), .fetch_req_o(fetch_req_o),
        .grp_valid_i(grp_valid_i), .grp_data_i(grp_data_i),
        .upd_valid_i(upd_valid_i), .upd_line_i(upd_line_i),
        .upd_taken_i(upd_taken_i), .upd_target_i(upd_target_i),
        .flush_i(flush_i), .flush_line_i(flush_line_i),
        .dec_valid_o(dec_valid_o), .dec_instr_o(dec_instr_o),
        .dec_ready_i(dec_ready_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Scoreboard at the falling edge: R6 order, R10 handshake, R8 flush clears.
    always @(negedge clk) begin
        if (rst_n) begin
            if (flush_i) begin
                sb.delete();
            end else begin
                if (dec_valid_o && dec_ready_i) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R10 spurious valid", int'(dec_instr_o), 0);
                    end else begin
                        chk(dec_instr_o == sb[0], "R6 order", int'(dec_instr_o), int'(sb[0]));
                        void'(sb.pop_front());
                    end
                end
                if (grp_valid_i && fetch_req_o) begin
                    for (int k = 0; k < LANES; k++) begin
                        sb.push_back({fetch_line_o, 8'(k)});
                    end
                end
            end
        end
    end

    task automatic do_flush(input logic [LINE_W-1:0] line);
        flush_i = 1'b1;
        flush_line_i = line;
        tick();
        flush_i = 1'b0;
    endtask

    task automatic do_update(input logic [LINE_W-1:0] line, input logic taken,
                             input logic [LINE_W-1:0] target);
        upd_valid_i = 1'b1;
        upd_line_i = line;
        upd_taken_i = taken;
        upd_target_i = target;
        tick();
        upd_valid_i = 1'b0;
    endtask

    task automatic predict_from(input logic [LINE_W-1:0] line,
                                input logic [LINE_W-1:0] exp, input string req);
        dec_ready_i = 1'b1;
        do_flush(line);
        grp_valid_i = 1'b1;
        tick();
        grp_valid_i = 1'b0;
        chk(fetch_line_o == exp, req, int'(fetch_line_o), int'(exp));
        chk(fetch_req_o == 1'b1, {req, " no stall"}, int'(fetch_req_o), 1);
        repeat (LANES) tick();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk(fetch_line_o == 8'h00, "R1 line", int'(fetch_line_o), 0);
        chk(fetch_req_o == 1'b1, "R1 req", int'(fetch_req_o), 1);
        chk(dec_valid_o == 1'b0, "R1 valid", int'(dec_valid_o), 0);
        rst_n = 1'b1;
        tick();
        chk(fetch_line_o == 8'h00, "R1 line after release", int'(fetch_line_o), 0);
    endtask

    task automatic t_sequential_fill();
        dec_ready_i = 1'b0;
        grp_valid_i = 1'b0;
        tick();
        chk(fetch_line_o == 8'h00, "R9 hold", int'(fetch_line_o), 0);
        grp_valid_i = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            tick();
            chk(fetch_line_o == LINE_W'(i), "R2 sequential", int'(fetch_line_o), i);
        end
        chk(fetch_req_o == 1'b0, "R7 full stall", int'(fetch_req_o), 0);
        tick();
        chk(fetch_line_o == 8'h03, "R7 no advance when full", int'(fetch_line_o), 3);
        chk(dec_valid_o == 1'b1, "R10 valid when full", int'(dec_valid_o), 1);
        grp_valid_i = 1'b0;
        dec_ready_i = 1'b1;
        repeat (DEPTH) tick();
        chk(dec_valid_o == 1'b0, "R10 drained", int'(dec_valid_o), 0);
        chk(fetch_req_o == 1'b1, "R7 room again", int'(fetch_req_o), 1);
        chk(sb.size() == 0, "R7 nothing dropped", sb.size(), 0);
    endtask

    task automatic t_counter_and_pointer();
        predict_from(8'h23, 8'h24, "R2 fresh entry not taken");
        do_update(8'h23, 1'b1, 8'h48);
        predict_from(8'h23, 8'h48, "R4 taken redirect");
        do_update(8'h23, 1'b0, 8'h00);
        do_update(8'h23, 1'b0, 8'h00);
        predict_from(8'h23, 8'h24, "R3 down to 0");
        do_update(8'h23, 1'b0, 8'h00);
        predict_from(8'h23, 8'h24, "R3 low saturation");
        do_update(8'h23, 1'b1, 8'h5A);
        predict_from(8'h23, 8'h24, "R3 one step from 0");
        do_update(8'h23, 1'b1, 8'h5A);
        predict_from(8'h23, 8'h5A, "R5 pointer rewritten");
        repeat (3) do_update(8'h23, 1'b1, 8'h5A);
        do_update(8'h23, 1'b0, 8'h77);
        predict_from(8'h23, 8'h5A, "R3 high saturation and R5 kept");
    endtask

    task automatic t_flush();
        do_flush(8'h10);
        dec_ready_i = 1'b0;
        grp_valid_i = 1'b1;
        tick();
        tick();
        chk(dec_valid_o == 1'b1, "R8 queue loaded", int'(dec_valid_o), 1);
        flush_i = 1'b1;
        flush_line_i = 8'h70;
        tick();
        flush_i = 1'b0;
        grp_valid_i = 1'b0;
        chk(fetch_line_o == 8'h70, "R8 redirect", int'(fetch_line_o), 8'h70);
        chk(dec_valid_o == 1'b0, "R8 emptied", int'(dec_valid_o), 0);
        chk(fetch_req_o == 1'b1, "R8 room", int'(fetch_req_o), 1);
    endtask

    task automatic t_alias();
        do_update(8'h11, 1'b1, 8'h66);
        predict_from(8'h31, 8'h66, "R11 shared entry");
    endtask

    task automatic t_handshake();
        dec_ready_i = 1'b0;
        do_flush(8'h00);
        grp_valid_i = 1'b1;
        tick();
        grp_valid_i = 1'b0;
        chk(dec_instr_o == 16'h0000, "R6 lane 0 first", int'(dec_instr_o), 0);
        tick();
        chk(dec_instr_o == 16'h0000, "R10 hold without ready", int'(dec_instr_o), 0);
        dec_ready_i = 1'b1;
        tick();
        chk(dec_instr_o == 16'h0001, "R10 advance on ready", int'(dec_instr_o), 1);
        repeat (LANES) tick();
    endtask

    initial begin
        t_reset();
        t_sequential_fill();
        t_counter_and_pointer();
        t_flush();
        t_alias();
        t_handshake();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule